// File: doc/BRIEF.md
# Flash Erase Block Select Guard

This block holds the erase-target selection for a sixteen-block flash array and answers one question for the erase sequencer: may the address presented now be erased? Software picks a target block by writing a single bit into one of two byte-wide select registers. The low register covers blocks 0 to 7 and the high register covers blocks 8 to 15. A register bus with a register select, a write strobe, write data and read data reaches both registers.

The guard allows at most one block to be selected across both registers. Any write that would leave two or more bits set, counted over all sixteen, clears the whole selection. The selection is also held clear in standby, and while the software write-enable qualifier is low. A separate address port decodes the array's uneven block layout: eight 4 KB blocks, one 32 KB block and seven 64 KB blocks. The `erase_ok` output is raised only when that address lies inside the selected block.

Top module: `erase_block_guard`

## Requirements
- R1: `reg_sel`=0 addresses the low register, whose bit n selects block n. `reg_sel`=1 addresses the high register, whose bit n selects block 8+n. A read returns the addressed register.
- R2: An active-low asynchronous reset clears both registers to 0x00.
- R3: While `hw_stby`, `sw_stby` or the inverse of `wr_en_q` is high, both registers are cleared on every clock and writes are ignored.
- R4: A write is merged with the other register's current byte. If the merged 16-bit value has more than one bit set, all sixteen bits become 0. This includes the case of one bit in each register.
- R5: While `flash_on` is low, `rdata` is 0x00 and writes leave the stored selection unchanged.
- R6: A write presented with `wr_stb` high takes effect at the next rising clock edge. It is not visible before that edge.
- R7: `erase_ok` is high only when `chk_addr` falls in the selected block. Blocks 0 to 7 are 4 KB each and cover 0x000000 to 0x007FFF in order.
- R8: Block 8 is 32 KB at 0x008000 to 0x00FFFF. Blocks 9 to 15 are 64 KB each and cover 0x010000 to 0x07FFFF in order.
- R9: Addresses at or above 0x080000 never give `erase_ok`. After an all-zero selection, `erase_ok` is low for every address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hw_stby | input | 1 | Hardware standby, clears selection |
| sw_stby | input | 1 | Software standby, clears selection |
| wr_en_q | input | 1 | Software write-enable qualifier; low clears selection |
| flash_on | input | 1 | On-chip flash enabled |
| reg_sel | input | 1 | 0 = low register, 1 = high register |
| wr_stb | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| chk_addr | input | ADDR_W | Address to test for erase permission |
| erase_ok | output | 1 | Address lies in the selected block |

## Verification
The bench builds the guard with its default geometry: a 24-bit address, 4 KB small blocks, a 32 KB middle block and 64 KB large blocks. These values bring every block edge, and the 0x080000 limit, within reach of directed addresses. The bench probes the first and last byte of each of the sixteen blocks, and the bytes just outside them. These probes expose any off-by-one in the decode of the unequal sizes. They also expose any selection that leaks into a neighbouring block.

// File: rtl/erase_block_guard.sv
module erase_block_guard #(
  parameter int ADDR_W   = 24,
  parameter int SMALL_LG = 12,
  parameter int MID_LG   = 15,
  parameter int BIG_LG   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hw_stby,
  input  logic              sw_stby,
  input  logic              wr_en_q,
  input  logic              flash_on,
  input  logic              reg_sel,
  input  logic              wr_stb,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic [ADDR_W-1:0] chk_addr,
  output logic              erase_ok
);

  localparam int NBLK = 16;

  function automatic int blk_lg(input int i);
    return (i < 8) ? SMALL_LG : ((i == 8) ? MID_LG : BIG_LG);
  endfunction

  function automatic longint blk_base(input int i);
    if (i < 8)  return longint'(i) << SMALL_LG;
    if (i == 8) return longint'(8) << SMALL_LG;
    return (longint'(8) << SMALL_LG) + (longint'(1) << MID_LG) + (longint'(i - 9) << BIG_LG);
  endfunction

  localparam longint TOP = blk_base(NBLK - 1) + (longint'(1) << BIG_LG);

  logic [15:0] sel_q;
  logic [15:0] merged;
  logic [15:0] nxt;
  logic [15:0] hit;

  wire hold_clr = hw_stby | sw_stby | ~wr_en_q;
  wire do_wr    = wr_stb & flash_on & ~hold_clr;

  assign merged = reg_sel ? {wdata, sel_q[7:0]} : {sel_q[15:8], wdata};
  assign nxt    = ($countones(merged) > 1) ? 16'h0000 : merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sel_q <= 16'h0000;
    else if (hold_clr) sel_q <= 16'h0000;
    else if (do_wr)    sel_q <= nxt;
  end

  assign rdata = !flash_on ? 8'h00 : (reg_sel ? sel_q[15:8] : sel_q[7:0]);

  for (genvar g = 0; g < NBLK; g++) begin : g_blk
    localparam int          LG   = blk_lg(g);
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(blk_base(g));
    assign hit[g] = (chk_addr >> LG) == (BASE >> LG);
  end

  assign erase_ok = |(hit & sel_q);

  // R3: held clear under standby or missing write enable
  p_held_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_stby || sw_stby || !wr_en_q) |=> (sel_q == 16'h0000));

  // R4: never more than one block selected
  p_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_q));

  // R5: flash disabled leaves selection untouched
  p_flash_off_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!flash_on && !hw_stby && !sw_stby && wr_en_q) |=> $stable(sel_q));

  // R6: single-bit low write with empty high register lands next edge
  p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && flash_on && wr_en_q && !hw_stby && !sw_stby && !reg_sel &&
     sel_q[15:8] == 8'h00 && $countones(wdata) <= 1) |=> (sel_q[7:0] == $past(wdata)));

  // R7: permission implies exactly one selected block
  p_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    erase_ok |-> ($countones(sel_q) == 1));

  // R9: nothing above the array is erasable
  p_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    erase_ok |-> (longint'(chk_addr) < TOP));

endmodule

// File: tb/erase_block_guard_tb.sv
module erase_block_guard_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        hw_stby = 0, sw_stby = 0, wr_en_q = 1, flash_on = 1;
  logic        reg_sel = 0, wr_stb = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata;
  logic [23:0] chk_addr = 0;
  logic        erase_ok;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  erase_block_guard u_dut (
    .clk(clk), .rst_n(rst_n), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .wr_en_q(wr_en_q), .flash_on(flash_on), .reg_sel(reg_sel),
    .wr_stb(wr_stb), .wdata(wdata), .rdata(rdata),
    .chk_addr(chk_addr), .erase_ok(erase_ok)
  );

  function automatic int ebase(input int i);
    if (i < 8)  return i * 32'h1000;
    if (i == 8) return 32'h8000;
    return (i - 8) * 32'h10000;
  endfunction
  function automatic int esize(input int i);
    return (i < 8) ? 32'h1000 : ((i == 8) ? 32'h8000 : 32'h10000);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; wdata = d; wr_stb = 1;
    @(negedge clk); wr_stb = 0;
  endtask

  task automatic rd_chk(input string req, input logic s, input logic [7:0] exp);
    reg_sel = s; #1; chk(req, rdata, exp);
  endtask

  task automatic ok_chk(input string req, input int a, input logic exp);
    chk_addr = a[23:0]; #1; chk(req, erase_ok, exp);
  endtask

  task automatic t_reset();
    rd_chk("R2 low after reset", 0, 8'h00);
    rd_chk("R2 high after reset", 1, 8'h00);
  endtask

  task automatic t_blocks();
    for (int i = 0; i < 16; i++) begin
      wr(0, 8'h00); wr(1, 8'h00);
      wr(i < 8 ? 1'b0 : 1'b1, 8'h01 << (i % 8));
      rd_chk("R1 readback", i < 8 ? 1'b0 : 1'b1, 8'h01 << (i % 8));
      rd_chk("R1 other reg empty", i < 8 ? 1'b1 : 1'b0, 8'h00);
      ok_chk(i < 8 ? "R7 first byte" : "R8 first byte", ebase(i), 1);
      ok_chk(i < 8 ? "R7 last byte" : "R8 last byte", ebase(i) + esize(i) - 1, 1);
      if (i > 0) ok_chk(i < 8 ? "R7 below" : "R8 below", ebase(i) - 1, 0);
      ok_chk(i < 8 ? "R7 above" : "R8 above", ebase(i) + esize(i), 0);
    end
  endtask

  task automatic t_limit();
    wr(0, 8'h00); wr(1, 8'h80);
    ok_chk("R9 0x080000", 32'h80000, 0);
    ok_chk("R9 0xFFFFFF", 32'hFFFFFF, 0);
    wr(1, 8'h00);
    for (int a = 0; a < 32'h90000; a += 32'h800) ok_chk("R9 zero selection", a, 0);
  endtask

  task automatic t_multi();
    wr(0, 8'h08); wr(1, 8'h03);
    rd_chk("R4 multi-bit high", 1, 8'h00);
    rd_chk("R4 multi-bit clears low", 0, 8'h00);
    wr(1, 8'h10); wr(0, 8'h01);
    rd_chk("R4 cross-register low", 0, 8'h00);
    rd_chk("R4 cross-register high", 1, 8'h00);
  endtask

  task automatic t_flash_off();
    wr(1, 8'h00); wr(0, 8'h02);
    @(negedge clk); flash_on = 0;
    rd_chk("R5 low reads zero", 0, 8'h00);
    rd_chk("R5 high reads zero", 1, 8'h00);
    wr(0, 8'h40);
    @(negedge clk); flash_on = 1;
    rd_chk("R5 write ignored", 0, 8'h02);
  endtask

  task automatic t_timing();
    wr(0, 8'h00);
    @(negedge clk); reg_sel = 0; wdata = 8'h20; wr_stb = 1;
    #1; chk("R6 before edge", rdata, 8'h00);
    @(posedge clk); #1; wr_stb = 0;
    chk("R6 after edge", rdata, 8'h20);
  endtask

  task automatic t_clear(input int kind);
    wr(1, 8'h00); wr(0, 8'h04);
    @(negedge clk);
    case (kind) 0: wr_en_q = 0; 1: hw_stby = 1; default: sw_stby = 1; endcase
    @(negedge clk);
    rd_chk("R3 cleared", 0, 8'h00);
    wr(0, 8'h01);
    rd_chk("R3 write ignored", 0, 8'h00);
    wr_en_q = 1; hw_stby = 0; sw_stby = 0;
    @(negedge clk);
    rd_chk("R3 stays clear", 0, 8'h00);
  endtask

  initial begin
    #(200000 * 10);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #23 rst_n = 1;
    @(negedge clk);
    t_reset();
    t_blocks();
    t_limit();
    t_multi();
    t_flash_off();
    t_timing();
    t_clear(0);
    t_clear(1);
    t_clear(2);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule